// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. It reads a radix tree of 64-bit entries held in memory. The tree has four levels, and the walk starts at the table whose physical base address is on `root_i`. Each request carries a virtual address and three access flags: write, user mode and execute. The block returns a single-cycle response. That response holds either the translated physical address or a 2-bit fault code.

The walk checks the upper address bits first. An address that is not canonical is rejected before any memory read. After that the walker fetches one entry per level through a memory port that allows only one transaction at a time. It combines the permission bits of every level it visits, and it can stop at a 1 GB or 2 MB large page. On success it writes the accessed bit back into the leaf entry, and on a write it also writes the dirty bit. The write-back happens only when the leaf word actually changes.

Top module: `pt_walker`

## Requirements
- R1: `req_ready_o` is high exactly when the walker is idle. A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high. Each accepted request produces exactly one `rsp_valid_o` pulse lasting one cycle, and `req_ready_o` is high again in the cycle after the pulse.
- R2: A virtual address is canonical when bits 63 to 48 all equal bit 47. A non-canonical address gets fault code 1 and causes no memory access. Canonical addresses in the upper half are translated normally.
- R3: Level 4 uses virtual bits 47:39 as its index, level 3 uses 38:30, level 2 uses 29:21 and level 1 uses 20:12. Each entry address is the table base plus 8 times the index. The first table base is `root_i`. Each later base is bits 51:12 of the previous entry, with the low 12 bits set to zero.
- R4: When bit 0 (present) of a fetched entry is clear, the walk stops with fault code 2.
- R5: A level-1 leaf gives a physical address made of entry bits 51:12 followed by virtual bits 11:0.
- R6: When bit 7 is set in a level-3 entry, the walk stops there. The physical address is entry bits 51:30 followed by virtual bits 29:0.
- R7: When bit 7 is set in a level-2 entry, the walk stops there. The physical address is entry bits 51:21 followed by virtual bits 20:0.
- R8: Bit 7 of a level-1 entry is ignored, so the entry is still treated as a 4 KB leaf.
- R9: The effective writable bit (bit 1) and user bit (bit 2) are the AND of those bits over all visited levels. The effective execute-disable bit (bit 63) is their OR. A protection violation gives fault code 3 and writes nothing to memory. A violation is any of these: a write without writable, a user access without user, or an execute with execute-disable set.
- R10: On success, the leaf entry is rewritten with bit 5 (accessed) set, and with bit 6 (dirty) also set when the access is a write. Only the leaf is rewritten, and only if its value changes.
- R11: At most one memory transaction is outstanding. A request on `mem_req_o` holds its address and direction until `mem_gnt_i` is high.
- R12: A response with a fault code other than 0 carries a physical address of zero. Fault code 0 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| root_i | input | 52 | Physical base address of the top-level table |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_va_i | input | 64 | Virtual address |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access is made in user mode |
| req_exec_i | input | 1 | Access is an instruction fetch |
| rsp_valid_o | output | 1 | Response valid (single-cycle pulse) |
| rsp_pa_o | output | 52 | Translated physical address |
| rsp_fault_o | output | 2 | 0 ok, 1 non-canonical, 2 not present, 3 protection |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | Transaction is a write |
| mem_addr_o | output | 52 | Entry byte address |
| mem_wdata_o | output | 64 | Entry write data |
| mem_gnt_i | input | 1 | Memory accepts the transaction |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |

## Verification
Some properties are checked on every cycle. These cover the single-cycle response pulse, zero physical address on faults, immediate rejection of non-canonical requests, and 8-byte alignment of memory addresses. They also cover a request that is held stable until granted, and write-backs that always carry the present and accessed bits.

Other behaviours only show up in the bench's directed scenarios, because they depend on table contents. These are the sequence of entry addresses, the offset width of each page size, and the way permissions combine across levels. The same applies to the choice between writing back the leaf and skipping the write. The bench memory grants only on every other cycle, so requests that must wait for a grant are also exercised.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    F_NONE     = 2'd0,
    F_NONCANON = 2'd1,
    F_NOTPRES  = 2'd2,
    F_PROT     = 2'd3
  } fault_e;

  typedef struct packed {
    logic w;
    logic u;
    logic nx;
  } perm_t;

  localparam int B_P  = 0;
  localparam int B_W  = 1;
  localparam int B_U  = 2;
  localparam int B_A  = 5;
  localparam int B_D  = 6;
  localparam int B_PS = 7;
  localparam int B_XD = 63;
endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
  parameter int VA_BITS = 48,
  parameter int OFF_W   = 12,
  parameter int IDX_W   = 9,
  parameter int LEVELS  = 4,
  parameter int LVL_W   = $clog2(LEVELS)
) (
  input  logic [63:OFF_W]   va_hi_i,
  input  logic [LVL_W-1:0]  lvl_i,
  output logic              canon_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int SIGN_LO = VA_BITS - 1;

  logic [IDX_W-1:0] idx_arr [LEVELS];

  // level g index sits just above the offset, g index widths up
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_arr[g] = va_hi_i[OFF_W + IDX_W*g +: IDX_W];
  end

  assign idx_o   = idx_arr[lvl_i];
  assign canon_o = (&va_hi_i[63:SIGN_LO]) | ~(|va_hi_i[63:SIGN_LO]);
endmodule

// File: rtl/pt_perm.sv
module pt_perm
  import pt_pkg::*;
(
  input  perm_t acc_i,
  input  logic  w_bit_i,
  input  logic  u_bit_i,
  input  logic  xd_bit_i,
  input  logic  write_i,
  input  logic  user_i,
  input  logic  exec_i,
  output perm_t acc_o,
  output logic  viol_o
);
  always_comb begin
    acc_o.w  = acc_i.w & w_bit_i;
    acc_o.u  = acc_i.u & u_bit_i;
    acc_o.nx = acc_i.nx | xd_bit_i;
    viol_o   = (write_i & ~acc_o.w) | (user_i & ~acc_o.u) | (exec_i & acc_o.nx);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_pkg::*;
#(
  parameter int VA_BITS     = 48,
  parameter int PA_W        = 52,
  parameter int OFF_W       = 12,
  parameter int IDX_W       = 9,
  parameter int LEVELS      = 4,
  parameter int HUGE_LEVELS = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PA_W-1:0] root_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [63:0]     req_va_i,
  input  logic            req_write_i,
  input  logic            req_user_i,
  input  logic            req_exec_i,
  output logic            rsp_valid_o,
  output logic [PA_W-1:0] rsp_pa_o,
  output logic [1:0]      rsp_fault_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [PA_W-1:0] mem_addr_o,
  output logic [63:0]     mem_wdata_o,
  input  logic            mem_gnt_i,
  input  logic            mem_rvalid_i,
  input  logic [63:0]     mem_rdata_i
);
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int ENT_SH = 3;
  localparam logic [PA_W-1:0] ONE = PA_W'(1);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_RESP} state_e;

  state_e           state_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  base_q;
  logic [63:0]      va_q;
  logic             wr_q, usr_q, exe_q;
  perm_t            acc_q, acc_nxt;
  logic [63:0]      wdata_q;
  logic [PA_W-1:0]  rsp_pa_q;
  fault_e           rsp_fault_q;

  logic [63:0]      va_sel;
  logic             canon;
  logic [IDX_W-1:0] idx;
  logic             viol;
  logic             leaf;
  logic [PA_W-1:0]  frame, pmask, leaf_pa;
  logic [63:0]      wb_word;

  assign va_sel = (state_q == S_IDLE) ? req_va_i : va_q;

  pt_va_split #(
    .VA_BITS(VA_BITS), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) u_split (
    .va_hi_i (va_sel[63:OFF_W]),
    .lvl_i   (lvl_q),
    .canon_o (canon),
    .idx_o   (idx)
  );

  pt_perm u_perm (
    .acc_i    (acc_q),
    .w_bit_i  (mem_rdata_i[B_W]),
    .u_bit_i  (mem_rdata_i[B_U]),
    .xd_bit_i (mem_rdata_i[B_XD]),
    .write_i  (wr_q),
    .user_i   (usr_q),
    .exec_i   (exe_q),
    .acc_o    (acc_nxt),
    .viol_o   (viol)
  );

  always_comb begin
    leaf    = (lvl_q == '0) ||
              (mem_rdata_i[B_PS] && int'(lvl_q) >= 1 && int'(lvl_q) <= HUGE_LEVELS);
    frame   = {mem_rdata_i[PA_W-1:OFF_W], {OFF_W{1'b0}}};
    pmask   = (ONE << (OFF_W + IDX_W*int'(lvl_q))) - ONE;
    leaf_pa = (frame & ~pmask) | (va_q[PA_W-1:0] & pmask);
    wb_word = mem_rdata_i;
    wb_word[B_A] = 1'b1;
    if (wr_q) wb_word[B_D] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      lvl_q       <= '0;
      base_q      <= '0;
      va_q        <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      exe_q       <= 1'b0;
      acc_q       <= '0;
      wdata_q     <= '0;
      rsp_pa_q    <= '0;
      rsp_fault_q <= F_NONE;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q  <= req_va_i;
          wr_q  <= req_write_i;
          usr_q <= req_user_i;
          exe_q <= req_exec_i;
          if (!canon) begin
            rsp_pa_q    <= '0;
            rsp_fault_q <= F_NONCANON;
            state_q     <= S_RESP;
          end else begin
            base_q  <= root_i;
            lvl_q   <= TOP_LVL;
            acc_q   <= '{w: 1'b1, u: 1'b1, nx: 1'b0};
            state_q <= S_RD_REQ;
          end
        end
        S_RD_REQ: if (mem_gnt_i) state_q <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rvalid_i) begin
          if (!mem_rdata_i[B_P]) begin
            rsp_pa_q    <= '0;
            rsp_fault_q <= F_NOTPRES;
            state_q     <= S_RESP;
          end else if (!leaf) begin
            base_q  <= frame;
            lvl_q   <= lvl_q - 1'b1;
            acc_q   <= acc_nxt;
            state_q <= S_RD_REQ;
          end else if (viol) begin
            rsp_pa_q    <= '0;
            rsp_fault_q <= F_PROT;
            state_q     <= S_RESP;
          end else begin
            rsp_pa_q    <= leaf_pa;
            rsp_fault_q <= F_NONE;
            wdata_q     <= wb_word;
            // skip the write when A/D are already set
            state_q     <= (wb_word != mem_rdata_i) ? S_WR_REQ : S_RESP;
          end
        end
        S_WR_REQ: if (mem_gnt_i) state_q <= S_RESP;
        S_RESP:   state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign rsp_valid_o = (state_q == S_RESP);
  assign rsp_pa_o    = rsp_pa_q;
  assign rsp_fault_o = rsp_fault_q;
  assign mem_req_o   = (state_q == S_RD_REQ) || (state_q == S_WR_REQ);
  assign mem_we_o    = (state_q == S_WR_REQ);
  assign mem_addr_o  = base_q + {{(PA_W-IDX_W-ENT_SH){1'b0}}, idx, {ENT_SH{1'b0}}};
  assign mem_wdata_o = wdata_q;

  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o); // R1
  AST_NONCANON_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && (req_va_i[63:VA_BITS-1] != '0) && (req_va_i[63:VA_BITS-1] != '1)
    |=> rsp_valid_o && rsp_fault_o == 2'd1 && !mem_req_o); // R2
  AST_ENTRY_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[ENT_SH-1:0] == '0); // R3
  AST_WB_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[B_A] && mem_wdata_o[B_P]); // R10
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R11
  AST_FAULT_PA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o != 2'd0 |-> rsp_pa_o == '0); // R12
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [51:0] root = 52'h1000;
  logic        req_valid = 1'b0, req_ready;
  logic [63:0] req_va = '0;
  logic        req_write = 1'b0, req_user = 1'b0, req_exec = 1'b0;
  logic        rsp_valid;
  logic [51:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid = 1'b0;
  logic [51:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata = '0;
  logic        gnt_en = 1'b0;

  int checks = 0, errors = 0;
  int rd_n = 0, wr_n = 0, mon_viol = 0;
  logic [51:0] rd_log [8];
  logic [63:0] mem [logic [51:0]];
  logic [51:0] got_pa;
  logic [1:0]  got_fault;
  logic        hold_chk = 1'b0;
  logic [51:0] hold_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_pt_walker (
    .clk_i(clk), .rst_ni(rst_n), .root_i(root),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_write_i(req_write), .req_user_i(req_user), .req_exec_i(req_exec),
    .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa), .rsp_fault_o(rsp_fault),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  assign mem_gnt = mem_req & gnt_en;

  always @(posedge clk) begin
    gnt_en <= ~gnt_en;
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_n++;
      end else begin
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
        mem_rvalid <= 1'b1;
        if (rd_n < 8) rd_log[rd_n] = mem_addr;
        rd_n++;
      end
    end
  end

  // R11 monitor: no new request with a read in flight; held requests stay stable
  always @(negedge clk) begin
    if (mem_rvalid && mem_req) mon_viol++;
    if (hold_chk && (!mem_req || mem_addr != hold_addr)) mon_viol++;
    hold_chk  = mem_req && !mem_gnt;
    hold_addr = mem_addr;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_va(int i4, int i3, int i2, int i1, int off);
    logic [47:0] v;
    v = {i4[8:0], i3[8:0], i2[8:0], i1[8:0], off[11:0]};
    return {{16{v[47]}}, v};
  endfunction

  task automatic translate(logic [63:0] va, logic w, logic u, logic x);
    int n = 0;
    rd_n = 0; wr_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = w; req_user = u; req_exec = x;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    if (n >= 200) begin
      errors++;
      $display("FAIL R1 response timeout actual=none expected=rsp_valid");
    end
    got_pa = rsp_pa; got_fault = rsp_fault;
  endtask

  task automatic t_reset;
    chk("R1 ready at reset", 64'(req_ready), 64'd1);
    chk("R1 no rsp at reset", 64'(rsp_valid), 64'd0);
    chk("R11 no mem req at reset", 64'(mem_req), 64'd0);
  endtask

  task automatic t_handshake;
    translate(mk_va(1, 2, 3, 4, 'h100), 0, 0, 0);
    @(negedge clk);
    chk("R1 rsp one cycle", 64'(rsp_valid), 64'd0);
    chk("R1 ready after rsp", 64'(req_ready), 64'd1);
  endtask

  task automatic t_4k;
    mem[52'h4020] = 64'h1234_5007;
    translate(mk_va(1, 2, 3, 4, 'hABC), 0, 1, 0);
    chk("R5 4k pa", 64'(got_pa), 64'h1234_5ABC);
    chk("R5 4k fault", 64'(got_fault), 64'd0);
    chk("R3 reads", 64'(rd_n), 64'd4);
    chk("R3 l4 addr", 64'(rd_log[0]), 64'h1008);
    chk("R3 l3 addr", 64'(rd_log[1]), 64'h2010);
    chk("R3 l2 addr", 64'(rd_log[2]), 64'h3018);
    chk("R3 l1 addr", 64'(rd_log[3]), 64'h4020);
    chk("R10 read sets A", mem[52'h4020], 64'h1234_5027);
    chk("R10 one write", 64'(wr_n), 64'd1);
    chk("R10 upper levels untouched", mem[52'h1008], 64'h2007);
    translate(mk_va(1, 2, 3, 4, 'hABC), 0, 0, 0);
    chk("R10 no write when unchanged", 64'(wr_n), 64'd0);
    translate(mk_va(1, 2, 3, 4, 'h001), 1, 0, 0);
    chk("R10 write sets D", mem[52'h4020], 64'h1234_5067);
    chk("R10 write count", 64'(wr_n), 64'd1);
    chk("R5 write pa", 64'(got_pa), 64'h1234_5001);
    translate(mk_va(1, 2, 3, 4, 'h001), 1, 0, 0);
    chk("R10 no rewrite of D", 64'(wr_n), 64'd0);
  endtask

  task automatic t_huge;
    translate(mk_va(1, 2, 5, 'h1A3, 'h456), 0, 0, 0);
    chk("R7 2M pa", 64'(got_pa), 64'h401A_3456);
    chk("R7 2M reads", 64'(rd_n), 64'd3);
    chk("R7 2M A set", mem[52'h3028], 64'h4000_00A7);
    translate(mk_va(1, 6, 'h55, 'h1A3, 'h456), 0, 0, 0);
    chk("R6 1G pa", 64'(got_pa), 64'h8ABA_3456);
    chk("R6 1G reads", 64'(rd_n), 64'd2);
    translate(mk_va(1, 2, 3, 7, 'h321), 0, 0, 0);
    chk("R8 l1 ps ignored pa", 64'(got_pa), 64'h5555_5321);
    chk("R8 l1 ps reads", 64'(rd_n), 64'd4);
  endtask

  task automatic t_notpres;
    translate(mk_va(9, 0, 0, 0, 0), 0, 0, 0);
    chk("R4 l4 missing fault", 64'(got_fault), 64'd2);
    chk("R12 l4 missing pa zero", 64'(got_pa), 64'd0);
    chk("R4 l4 missing reads", 64'(rd_n), 64'd1);
    translate(mk_va(1, 2, 3, 8, 0), 1, 0, 0);
    chk("R4 l1 missing fault", 64'(got_fault), 64'd2);
    chk("R4 l1 missing no write", 64'(wr_n), 64'd0);
  endtask

  task automatic t_canon;
    translate(64'h0000_8000_0000_0000, 0, 0, 0);
    chk("R2 noncanon fault", 64'(got_fault), 64'd1);
    chk("R2 noncanon no reads", 64'(rd_n), 64'd0);
    chk("R12 noncanon pa zero", 64'(got_pa), 64'd0);
    translate(64'hFFFF_0000_0000_0000, 0, 0, 0);
    chk("R2 noncanon high fault", 64'(got_fault), 64'd1);
    translate(64'hFFFF_8000_0000_1234, 0, 0, 0);
    chk("R2 upper half fault", 64'(got_fault), 64'd0);
    chk("R2 upper half pa", 64'(got_pa), 64'hC000_1234);
  endtask

  task automatic t_prot;
    translate(mk_va(1, 2, 10, 0, 'h10), 1, 0, 0);
    chk("R9 write via readonly level", 64'(got_fault), 64'd3);
    chk("R12 prot pa zero", 64'(got_pa), 64'd0);
    chk("R9 prot no write", 64'(wr_n), 64'd0);
    chk("R9 prot leaf unchanged", mem[52'h5000], 64'h6666_6007);
    translate(mk_va(1, 2, 10, 0, 'h10), 0, 1, 0);
    chk("R9 user read ok", 64'(got_pa), 64'h6666_6010);
    translate(mk_va(1, 2, 10, 1, 'h20), 0, 1, 0);
    chk("R9 user on kernel page", 64'(got_fault), 64'd3);
    translate(mk_va(1, 2, 10, 1, 'h20), 0, 0, 0);
    chk("R9 kernel read ok", 64'(got_pa), 64'h7777_7020);
    translate(mk_va(1, 2, 10, 2, 0), 0, 0, 1);
    chk("R9 exec on xd", 64'(got_fault), 64'd3);
    translate(mk_va(1, 2, 10, 2, 0), 0, 0, 0);
    chk("R9 read on xd ok", 64'(got_fault), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mem[52'h1008] = 64'h2007;
    mem[52'h1800] = 64'h2007;
    mem[52'h2000] = 64'hC000_0087;
    mem[52'h2010] = 64'h3007;
    mem[52'h2030] = 64'h8000_0087;
    mem[52'h3018] = 64'h4007;
    mem[52'h3028] = 64'h4000_0087;
    mem[52'h3050] = 64'h5005;
    mem[52'h4038] = 64'h5555_5087;
    mem[52'h5000] = 64'h6666_6007;
    mem[52'h5008] = 64'h7777_7003;
    mem[52'h5010] = 64'h8000_0000_8888_8007;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_4k();
    t_handshake();
    t_huge();
    t_notpres();
    t_canon();
    t_prot();
    chk("R11 monitor violations", 64'(mon_viol), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule